// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block takes drawing commands as 32-bit words pushed into a small command queue and turns them into pixel accesses on a simple synchronous memory port. It runs two operations. A solid fill writes one colour into every pixel of a rectangle. A copy reads each pixel of a source rectangle and writes it to the matching pixel of a destination rectangle. Every memory access is one pixel. The pixel address is the row number placed above the column number.

Software first reads the free-slot count until there is room for a whole packet. It then pushes the packet words one after another. It polls the status word until the busy bits are clear. The fill colour lives in its own register, which is written before the fill packet is queued. For a copy, software picks the scan direction on each axis from the relative positions of source and destination. An overlapping copy then never overwrites a source pixel before that pixel has been read.

Top module: `rect_blit_engine`

## Requirements
- R1: A fill packet has three words: the exact opcode 0x09410000, then a position word, then a size word. Position and size words hold Y in bits 31:16 and X in bits 15:0. The fill writes the captured colour to every pixel, X fastest then Y, both increasing.
- R2: A copy packet has four words: a control word, then the source position, then the destination position, then the size. The control word has 0x0D in bits 31:24 and a value from 0x44 to 0x47 in bits 23:16. Each pixel is one read of the source followed by one write of that data to the destination.
- R3: Control word bit 16 makes X step downward and bit 17 makes Y step downward, each starting from the far edge of the rectangle. With the code chosen from the source and destination positions, an overlapping copy leaves the destination equal to the source as it was before the copy.
- R4: The colour register at offset 0x480 is written and read back through the register port, never through the queue. Its value is captured when a fill starts, so a later write does not change a fill already running.
- R5: The status register at offset 0x400 has bit 0 set while a packet is executing and bit 4 set while the queue holds words. Together they stay set from the first queued word until the last pixel write is accepted.
- R6: The register at offset 0x408 reads 16 minus the number of queued words.
- R7: A push into a full queue is dropped. It sets status bit 2, which stays set until reset.
- R8: A packet starts only after all of its words are in the queue. Before that, no memory request is made.
- R9: A head word that is neither a fill opcode nor a valid copy control word is discarded alone, and the next word is decoded as a new packet head.
- R10: A packet with zero width or zero height is consumed without any memory access.
- R11: Once raised, a memory request holds its direction, address and write data steady until the cycle in which ready is high.
- R12: The pixel address is the low 10 bits of Y placed above the low 10 bits of X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Push cmdData into the command queue |
| cmdData | input | 32 | Command word |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 20 | Pixel address |
| memWData | output | 16 | Pixel write data |
| memRData | input | 16 | Pixel read data, valid when ready is high on a read |
| memReady | input | 1 | Memory accepts the request this cycle |

## Verification
Fills are run once with a partial packet, to show that execution waits, and once with a colour write made while the fill is running. Copies that do not overlap are run with a slow memory, which exposes any request that is not held steady. Four overlapping copies, one for each direction code, produce a wrong destination image if either axis scans the wrong way. Zero-sized rectangles, bad head words and a deliberately overfilled queue under a stalled memory show whether packets are consumed cleanly and whether the overflow flag is kept.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [31:0] FILL_OP    = 32'h0941_0000;
  localparam logic [7:0]  COPY_TAG   = 8'h0D;
  localparam logic [5:0]  COPY_CODE  = 6'b010001;   // bits 23:18 of 0x44..0x47
  localparam logic [11:0] REG_STATUS = 12'h400;
  localparam logic [11:0] REG_FREE   = 12'h408;
  localparam logic [11:0] REG_COLOUR = 12'h480;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} walkState_t;

  typedef struct packed {
    logic load;       // capture packet fields
    logic loadCopy;   // packet is a copy
    logic decX;       // scan X downward
    logic decY;       // scan Y downward
    logic step;       // advance to next pixel
    logic latchRead;  // capture read data
    logic selSrc;     // address source rectangle
  } dpCtrl_t;
endpackage

// File: rtl/blit_cmd_fifo.sv
module blit_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pushEn,
  input  logic [WORD_W-1:0]     pushData,
  input  logic [2:0]            popCount,
  output logic [CNT_W-1:0]      count,
  output logic [3:0][WORD_W-1:0] peek,
  output logic                  overflow
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              full, accept;

  assign full   = (count == CNT_W'(DEPTH));
  assign accept = pushEn && !full;

  always_ff @(posedge clk) begin
    if (accept) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + PTR_W'(1);
      if (pushEn && full) overflow <= 1'b1;
      rdPtr <= rdPtr + PTR_W'(popCount);
      count <= count + CNT_W'(accept) - CNT_W'(popCount);
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_peek
    assign peek[k] = store[rdPtr + PTR_W'(k)];
  end

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  assert_pop_within_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(popCount) <= count);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [3:0][31:0]  peek,
  input  logic              lastPixel,
  input  logic              copyMode,
  input  logic              memReady,
  output logic [2:0]        popCount,
  output dpCtrl_t           ctl,
  output logic              memReq,
  output logic              memWe,
  output logic              active
);
  walkState_t state, nextState;
  logic isFill, isCopy, fillEmpty, copyEmpty;

  assign isFill    = (peek[0] == FILL_OP);
  assign isCopy    = (peek[0][31:24] == COPY_TAG) && (peek[0][23:18] == COPY_CODE);
  assign fillEmpty = (peek[2][31:16] == '0) || (peek[2][15:0] == '0);
  assign copyEmpty = (peek[3][31:16] == '0) || (peek[3][15:0] == '0);
  assign active    = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    popCount  = 3'd0;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fifoCount != '0) begin
          if (isFill) begin
            if (fifoCount >= CNT_W'(3)) begin
              popCount = 3'd3;
              ctl.load = 1'b1;
              if (!fillEmpty) nextState = ST_WRITE;
            end
          end else if (isCopy) begin
            if (fifoCount >= CNT_W'(4)) begin
              popCount     = 3'd4;
              ctl.load     = 1'b1;
              ctl.loadCopy = 1'b1;
              ctl.decX     = peek[0][16];
              ctl.decY     = peek[0][17];
              if (!copyEmpty) nextState = ST_READ;
            end
          end else begin
            popCount = 3'd1;   // unknown head word: drop and resync
          end
        end
      end
      ST_READ: begin
        memReq     = 1'b1;
        ctl.selSrc = 1'b1;
        if (memReady) begin
          ctl.latchRead = 1'b1;
          nextState     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          ctl.step = 1'b1;
          if (lastPixel)     nextState = ST_IDLE;
          else if (copyMode) nextState = ST_READ;
          else               nextState = ST_WRITE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && (memWe == $past(memWe))));
  assert_no_load_short_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (fifoCount >= CNT_W'(3)));
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int AX_W = 10,
  parameter int AY_W = 10,
  parameter int PIX_W = 16,
  localparam int ADDR_W = AX_W + AY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [3:0][31:0]  peek,
  input  logic [PIX_W-1:0]  colour,
  input  logic [PIX_W-1:0]  memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]  memWData,
  output logic              lastPixel,
  output logic              copyMode
);
  logic [COORD_W-1:0] srcX, srcY, dstX, dstY, width, height, col, row;
  logic [COORD_W-1:0] offX, offY, baseX, baseY;
  logic               decXq, decYq;
  logic [PIX_W-1:0]   colourLat, readLat;
  logic               lastCol;

  assign lastCol   = (col == width - COORD_W'(1));
  assign lastPixel = lastCol && (row == height - COORD_W'(1));

  assign offX  = decXq ? (width  - COORD_W'(1) - col) : col;
  assign offY  = decYq ? (height - COORD_W'(1) - row) : row;
  assign baseX = ctl.selSrc ? srcX : dstX;
  assign baseY = ctl.selSrc ? srcY : dstY;

  assign memAddr  = {AY_W'(baseY + offY), AX_W'(baseX + offX)};
  assign memWData = copyMode ? readLat : colourLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {srcX, srcY, dstX, dstY, width, height} <= '0;
      col       <= '0;
      row       <= '0;
      decXq     <= 1'b0;
      decYq     <= 1'b0;
      copyMode  <= 1'b0;
      colourLat <= '0;
      readLat   <= '0;
    end else begin
      if (ctl.load) begin
        col       <= '0;
        row       <= '0;
        copyMode  <= ctl.loadCopy;
        decXq     <= ctl.decX;
        decYq     <= ctl.decY;
        colourLat <= colour;
        if (ctl.loadCopy) begin
          srcX   <= COORD_W'(peek[1][15:0]);
          srcY   <= COORD_W'(peek[1][31:16]);
          dstX   <= COORD_W'(peek[2][15:0]);
          dstY   <= COORD_W'(peek[2][31:16]);
          width  <= COORD_W'(peek[3][15:0]);
          height <= COORD_W'(peek[3][31:16]);
        end else begin
          srcX   <= '0;
          srcY   <= '0;
          dstX   <= COORD_W'(peek[1][15:0]);
          dstY   <= COORD_W'(peek[1][31:16]);
          width  <= COORD_W'(peek[2][15:0]);
          height <= COORD_W'(peek[2][31:16]);
        end
      end else if (ctl.step) begin
        if (lastCol) begin
          col <= '0;
          row <= row + COORD_W'(1);
        end else begin
          col <= col + COORD_W'(1);
        end
      end
      if (ctl.latchRead) readLat <= memRData;
    end
  end

  assert_no_step_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> ((width != '0) && (height != '0)));
  assert_walk_in_rect_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> ((col < width) && (row < height)));
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int COORD_W = 16,
  parameter int AX_W = 10,
  parameter int AY_W = 10,
  parameter int PIX_W = 16,
  localparam int ADDR_W = AX_W + AY_W,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [31:0]       cmdData,
  input  logic              regWr,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]  memWData,
  input  logic [PIX_W-1:0]  memRData,
  input  logic              memReady
);
  logic [CNT_W-1:0] fifoCount;
  logic [3:0][31:0] peek;
  logic             overflow, active, lastPixel, copyMode;
  logic [2:0]       popCount;
  dpCtrl_t          ctl;
  logic [31:0]      colourReg, statusWord;

  blit_cmd_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(32)) uFifo (
    .clk(clk), .rstN(rstN), .pushEn(cmdWr), .pushData(cmdData),
    .popCount(popCount), .count(fifoCount), .peek(peek), .overflow(overflow)
  );

  blit_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .peek(peek),
    .lastPixel(lastPixel), .copyMode(copyMode), .memReady(memReady),
    .popCount(popCount), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .active(active)
  );

  blit_datapath #(.COORD_W(COORD_W), .AX_W(AX_W), .AY_W(AY_W), .PIX_W(PIX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .peek(peek),
    .colour(colourReg[PIX_W-1:0]), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData),
    .lastPixel(lastPixel), .copyMode(copyMode)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                                  colourReg <= '0;
    else if (regWr && regAddr == REG_COLOUR)    colourReg <= regWData;
  end

  always_comb begin
    statusWord    = '0;
    statusWord[0] = active;
    statusWord[2] = overflow;
    statusWord[4] = (fifoCount != '0);
  end

  always_comb begin
    regRData = '0;
    case (regAddr)
      REG_STATUS: regRData = statusWord;
      REG_FREE:   regRData = 32'(FIFO_DEPTH) - 32'(fifoCount);
      REG_COLOUR: regRData = colourReg;
      default:    regRData = '0;
    endcase
  end

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && $stable(memWData)));
  assert_busy_during_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> statusWord[0]);
endmodule

// File: tb/rect_blit_engine_test.sv
module rect_blit_engine_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWr = 1'b0;
  logic [31:0] cmdData = '0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        memReq, memWe;
  logic [19:0] memAddr;
  logic [15:0] memWData;
  logic [15:0] memRData = '0;
  logic        memReady = 1'b0;

  always #5 clk = ~clk;

  rect_blit_engine uut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .regWr(regWr), .regAddr(regAddr), .regWData(regWData), .regRData(regRData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memReady(memReady)
  );

  typedef struct { bit we; int addr; int data; } txn_t;
  txn_t        expQ[$];
  logic [15:0] mem [int];
  logic [15:0] refMem [int];
  int checks = 0, errors = 0, txnSeen = 0, readyMode = 0;
  bit toggle = 1'b0;

  function automatic logic [15:0] initVal(int a);
    return 16'(a * 7 + 3) ^ 16'hA5A5;
  endfunction
  function automatic logic [15:0] rdMem(int a);
    return mem.exists(a) ? mem[a] : initVal(a);
  endfunction
  function automatic logic [15:0] rdRef(int a);
    return refMem.exists(a) ? refMem[a] : initVal(a);
  endfunction
  function automatic int pa(int x, int y);
    return (y % 1024) * 1024 + (x % 1024);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder and per-access comparison against the reference queue
  always @(negedge clk) begin
    toggle = ~toggle;
    case (readyMode)
      0:       memReady = 1'b1;
      1:       memReady = toggle;
      default: memReady = 1'b0;
    endcase
    memRData = '0;
    if (rstN && memReq && !memWe) memRData = rdMem(int'(memAddr));
    if (rstN && memReq && memReady) begin
      txnSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected access addr", int'(memAddr), 0);
      end else begin
        txn_t t;
        t = expQ.pop_front();
        check(memWe == t.we, "R2", "access direction", int'(memWe), int'(t.we));
        check(int'(memAddr) == t.addr, "R12", "pixel address/order (R3)", int'(memAddr), t.addr);
        if (t.we) check(int'(memWData) == t.data, "R1", "write data", int'(memWData), t.data);
        if (memWe) mem[int'(memAddr)] = memWData;
      end
    end
  end

  task automatic push(logic [31:0] w);
    cmdWr = 1'b1; cmdData = w;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRData;
  endtask

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitIdle(string req);
    logic [31:0] s;
    bit done = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) begin
      @(negedge clk);
      rdReg(12'h400, s);
      if ((s & 32'h131) == 0) done = 1'b1;
    end
    check(done, req, "busy never cleared", int'(s), 0);
    check(expQ.size() == 0, req, "accesses left when idle", expQ.size(), 0);
  endtask

  task automatic modelFill(int x, int y, int w, int h, int c);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int a = pa(x + k, y + r);
        expQ.push_back('{1'b1, a, c});
        refMem[a] = 16'(c);
      end
  endtask

  task automatic modelCopy(int sx, int sy, int dx, int dy, int w, int h, bit dX, bit dY);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int yy = dY ? h - 1 - r : r;
        int xx = dX ? w - 1 - k : k;
        int s = pa(sx + xx, sy + yy);
        int d = pa(dx + xx, dy + yy);
        logic [15:0] v = rdRef(s);
        expQ.push_back('{1'b0, s, 0});
        expQ.push_back('{1'b1, d, int'(v)});
        refMem[d] = v;
      end
  endtask

  task automatic doCopy(int sx, int sy, int dx, int dy, int w, int h);
    logic [7:0] code;
    logic [15:0] snap [int];
    if (sx >= dx && sy >= dy)      code = 8'h44;
    else if (sx >= dx && sy <= dy) code = 8'h46;
    else if (sx <= dx && sy >= dy) code = 8'h45;
    else                           code = 8'h47;
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) snap[r * 64 + k] = rdRef(pa(sx + k, sy + r));
    modelCopy(sx, sy, dx, dy, w, h, code[0], code[1]);
    push(32'h0D00_0000 | (32'(code) << 16));
    push(32'((sy << 16) | sx));
    push(32'((dy << 16) | dx));
    push(32'((h << 16) | w));
    waitIdle("R2");
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++)
        check(rdMem(pa(dx + k, dy + r)) == snap[r * 64 + k], "R3",
              "overlap copy result", int'(rdMem(pa(dx + k, dy + r))), int'(snap[r * 64 + k]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seen;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rdReg(12'h400, d); check(d == 0, "R5", "status after reset", int'(d), 0);
    rdReg(12'h408, d); check(d == 16, "R6", "free slots after reset", int'(d), 16);
    check(memReq == 1'b0, "R8", "request after reset", int'(memReq), 0);

    wrReg(12'h480, 32'h0000_1234);
    rdReg(12'h480, d); check(d == 32'h1234, "R4", "colour readback", int'(d), 32'h1234);
    rdReg(12'h408, d); check(d == 16, "R4", "colour write bypasses queue", int'(d), 16);

    // partial fill packet must wait
    push(32'h0941_0000);
    push(32'h0003_0005);
    repeat (3) @(negedge clk);
    check(memReq == 1'b0, "R8", "request before packet complete", int'(memReq), 0);
    rdReg(12'h408, d); check(d == 14, "R6", "free slots with two queued", int'(d), 14);
    rdReg(12'h400, d); check((d & 32'h131) == 32'h10, "R5", "busy while queued", int'(d), 32'h10);
    modelFill(5, 3, 4, 2, 16'h1234);
    push(32'h0002_0004);
    waitIdle("R1");
    rdReg(12'h400, d); check(d == 0, "R5", "status after fill", int'(d), 0);

    // colour captured at fill start
    readyMode = 1;
    wrReg(12'h480, 32'h0000_BEEF);
    modelFill(40, 7, 3, 2, 16'hBEEF);
    push(32'h0941_0000);
    push(32'h0007_0028);
    push(32'h0002_0003);
    repeat (2) @(negedge clk);
    wrReg(12'h480, 32'h0000_0000);
    waitIdle("R4");

    // copies: separate rectangles, then four overlapping directions
    doCopy(100, 50, 10, 5, 3, 3);
    readyMode = 0;
    doCopy(20, 20, 22, 21, 5, 4);
    doCopy(22, 21, 20, 20, 5, 4);
    doCopy(20, 25, 23, 22, 5, 4);
    doCopy(23, 22, 20, 25, 5, 4);

    // zero-sized packets
    seen = txnSeen;
    push(32'h0941_0000); push(32'h0001_0001); push(32'h0003_0000);
    push(32'h0D44_0000); push(32'h0002_0002); push(32'h0009_0009); push(32'h0000_0004);
    waitIdle("R10");
    check(txnSeen == seen, "R10", "accesses for empty rectangles", txnSeen - seen, 0);
    rdReg(12'h408, d); check(d == 16, "R10", "empty packets consumed", int'(d), 16);

    // unknown head words then a valid fill
    wrReg(12'h480, 32'h0000_0077);
    push(32'h1234_5678);
    push(32'h0D80_0000);
    modelFill(60, 60, 2, 1, 16'h0077);
    push(32'h0941_0000); push(32'h003C_003C); push(32'h0001_0002);
    waitIdle("R9");
    check(rdMem(pa(61, 60)) == 16'h0077, "R9", "fill after resync", int'(rdMem(pa(61, 60))), 16'h77);

    // overflow with stalled memory
    readyMode = 2;
    modelFill(30, 30, 2, 1, 16'h0077);
    push(32'h0941_0000); push(32'h001E_001E); push(32'h0001_0002);
    for (int i = 0; i < 17; i++) push(32'hFFFF_0000);
    rdReg(12'h408, d); check(d == 0, "R6", "free slots when full", int'(d), 0);
    rdReg(12'h400, d); check(d[2] == 1'b1, "R7", "overflow flag", int'(d[2]), 1);
    check(memReq == 1'b1, "R11", "request held during stall", int'(memReq), 1);
    readyMode = 0;
    waitIdle("R7");
    rdReg(12'h400, d); check(d == 32'h4, "R7", "overflow sticky after drain", int'(d), 4);
    rdReg(12'h408, d); check(d == 16, "R6", "free slots after drain", int'(d), 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule